// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits on the write side of a flash-style memory front end. Each cycle with `wr_valid` high is one bus write, made of an address and a data word. The block follows the stream of writes and detects the magic address/data sequences that unlock memory operations. For every sequence it recognises, it issues a one-cycle command pulse. The pulse carries an operation code together with the address and data of the write that completed the sequence. Downstream engines carry out the command and hold `busy` high while they work. Any write that arrives while `busy` is high is dropped.

Two sticky modes change how writes are handled. The first is a bypass mode, entered through a six-write sequence. In this mode every write is a program, whatever data it carries, and only a reset ends the mode. The second is an identification mode. While it is active, a separate read port returns the manufacturer and device codes.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, `cmd_valid` is 0, `bypass_active` and `id_active` are 0, `id_rdata` is 0, and the decoder waits for the first write of a sequence.
- R2: The writes AA@5555, 55@2AAA, A0@5555, followed by any write, give one pulse with `cmd_op`=1 (program). The pulse carries that last write's address and data and appears the cycle after it. The earlier writes give no pulse.
- R3: The six writes AA@5555, 55@2AAA, 80@5555, AA@5555, 55@2AAA, 10@5555 give `cmd_op`=2 (chip erase).
- R4: The same five-write start, ending with 30 at any address, gives `cmd_op`=3 (sector erase) with that address. Ending instead with 40 at any address gives `cmd_op`=4 (sector lockout).
- R5: The same five-write start, ending with A0@5555, sets `bypass_active` and gives no pulse. From then on, every write gives `cmd_op`=1 with its own address and data, including writes of B0, 30 and F0.
- R6: Once set, `bypass_active` stays 1 until `rst`. After `rst` it is 0.
- R7: From idle, B0 at any address gives `cmd_op`=5 (suspend). From idle, 30 at any address gives `cmd_op`=6 (resume), and the pulse carries that address.
- R8: AA@5555, 55@2AAA, 90@5555 gives `cmd_op`=7 and sets `id_active`. Either AA@5555, 55@2AAA, F0@5555 or a single F0 write gives `cmd_op`=8 and clears `id_active`.
- R9: While `id_active` is 1, `id_rdata` is 1F one cycle after `rd_addr`=0, and C0 one cycle after `rd_addr`=1. In every other case `id_rdata` is 0.
- R10: A write with `busy`=1 gives no pulse and leaves the sequence position and the modes unchanged.
- R11: A write that does not match the next expected step of a sequence returns the decoder to idle without a pulse. Later writes are then decoded from the start.
- R12: Only `wr_data[7:0]` and `wr_addr[15:0]` take part in matching. The upper bits are don't-care for matching, but they are still passed through on `cmd_addr` and `cmd_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | One bus write this cycle |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| busy | input | 1 | Downstream engine is executing a command |
| rd_addr | input | ADDR_W | Read address for identification codes |
| cmd_valid | output | 1 | One-cycle command pulse |
| cmd_op | output | 4 | Operation code (1 program … 8 leave ID) |
| cmd_addr | output | ADDR_W | Address of the write that completed the command |
| cmd_data | output | DATA_W | Data of the write that completed the command |
| bypass_active | output | 1 | Single-write program mode is on |
| id_active | output | 1 | Identification mode is on |
| id_rdata | output | DATA_W | Identification code for `rd_addr` |

## Verification
The assertions assume that `wr_valid`, `busy` and the address and data buses are synchronous levels with known values at every rising edge. They also assume that a write is counted once for each cycle in which `wr_valid` is high, so they check a pulse only against the write and `busy` state of the previous edge. The stimulus changes every input on the falling clock edge and holds each write for exactly one cycle. It draws addresses and codes mostly from the magic values, with random upper bits and random noise mixed in, so that partial and broken sequences happen often. The bench reaches bypass mode only in a directed section that begins just after a reset, which keeps the random section's reference model in step with the design.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [3:0] {
    OP_NONE       = 4'd0,
    OP_PROG       = 4'd1,
    OP_CHIP_ERASE = 4'd2,
    OP_SECT_ERASE = 4'd3,
    OP_SECT_LOCK  = 4'd4,
    OP_SUSPEND    = 4'd5,
    OP_RESUME     = 4'd6,
    OP_ID_ENTER   = 4'd7,
    OP_ID_EXIT    = 4'd8
  } cmd_op_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_KEY1,
    S_KEY2,
    S_ARM,
    S_EXT3,
    S_EXT4,
    S_EXT5
  } seq_state_e;

  localparam int unsigned MATCH_AW = 16;
  localparam int unsigned MATCH_DW = 8;

  localparam logic [MATCH_AW-1:0] KEY_ADDR_HI = 16'h5555;
  localparam logic [MATCH_AW-1:0] KEY_ADDR_LO = 16'h2AAA;

  localparam logic [MATCH_DW-1:0] CD_UNLOCK_A = 8'hAA;
  localparam logic [MATCH_DW-1:0] CD_UNLOCK_B = 8'h55;
  localparam logic [MATCH_DW-1:0] CD_PROG     = 8'hA0;
  localparam logic [MATCH_DW-1:0] CD_EXTEND   = 8'h80;
  localparam logic [MATCH_DW-1:0] CD_CHIP     = 8'h10;
  localparam logic [MATCH_DW-1:0] CD_SECTOR   = 8'h30;
  localparam logic [MATCH_DW-1:0] CD_LOCK     = 8'h40;
  localparam logic [MATCH_DW-1:0] CD_SUSPEND  = 8'hB0;
  localparam logic [MATCH_DW-1:0] CD_ID_IN    = 8'h90;
  localparam logic [MATCH_DW-1:0] CD_ID_OUT   = 8'hF0;

endpackage

// File: rtl/flash_key_match.sv
module flash_key_match
  import flash_cmd_pkg::*;
(
  input  logic [MATCH_AW-1:0] addr_lo,
  input  logic [MATCH_DW-1:0] data_lo,
  output logic                at_hi,
  output logic                at_lo,
  output logic [MATCH_DW-1:0] code
);
  // Only the low slices reach this point (R12).
  always_comb begin
    at_hi = (addr_lo == KEY_ADDR_HI);
    at_lo = (addr_lo == KEY_ADDR_LO);
    code  = data_lo;
  end
endmodule

// File: rtl/flash_seq_fsm.sv
module flash_seq_fsm
  import flash_cmd_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                fire,
  input  logic                at_hi,
  input  logic                at_lo,
  input  logic [MATCH_DW-1:0] code,
  output cmd_op_e             ev_op,
  output logic                bypass_q,
  output logic                id_q
);
  seq_state_e state_q, state_d;
  logic       bypass_d, id_d;

  always_comb begin
    state_d  = state_q;
    bypass_d = bypass_q;
    id_d     = id_q;
    ev_op    = OP_NONE;
    if (fire) begin
      if (bypass_q) begin
        ev_op = OP_PROG;                     // R5: every write programs
      end else begin
        case (state_q)
          S_IDLE: begin
            if (at_hi && code == CD_UNLOCK_A) state_d = S_KEY1;
            else if (code == CD_SUSPEND)      ev_op = OP_SUSPEND;
            else if (code == CD_SECTOR)       ev_op = OP_RESUME;
            else if (code == CD_ID_OUT) begin
              ev_op = OP_ID_EXIT;
              id_d  = 1'b0;
            end
          end
          S_KEY1: state_d = (at_lo && code == CD_UNLOCK_B) ? S_KEY2 : S_IDLE;
          S_KEY2: begin
            state_d = S_IDLE;
            if (at_hi) begin
              case (code)
                CD_PROG:   state_d = S_ARM;
                CD_EXTEND: state_d = S_EXT3;
                CD_ID_IN: begin
                  ev_op = OP_ID_ENTER;
                  id_d  = 1'b1;
                end
                CD_ID_OUT: begin
                  ev_op = OP_ID_EXIT;
                  id_d  = 1'b0;
                end
                default: state_d = S_IDLE;
              endcase
            end
          end
          S_ARM: begin
            ev_op   = OP_PROG;
            state_d = S_IDLE;
          end
          S_EXT3: state_d = (at_hi && code == CD_UNLOCK_A) ? S_EXT4 : S_IDLE;
          S_EXT4: state_d = (at_lo && code == CD_UNLOCK_B) ? S_EXT5 : S_IDLE;
          S_EXT5: begin
            state_d = S_IDLE;
            if (code == CD_SECTOR)                ev_op = OP_SECT_ERASE;
            else if (code == CD_LOCK)             ev_op = OP_SECT_LOCK;
            else if (at_hi && code == CD_CHIP)    ev_op = OP_CHIP_ERASE;
            else if (at_hi && code == CD_PROG)    bypass_d = 1'b1;
          end
          default: state_d = S_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= S_IDLE;
      bypass_q <= 1'b0;
      id_q     <= 1'b0;
    end else begin
      state_q  <= state_d;
      bypass_q <= bypass_d;
      id_q     <= id_d;
    end
  end

  // R6: bypass only leaves through reset
  p_bypass_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    bypass_q |=> bypass_q);

  // R10: without an accepted write nothing moves
  p_hold_without_write_r10: assert property (@(posedge clk) disable iff (rst)
    !fire |=> ($stable(state_q) && $stable(id_q)));

endmodule

// File: rtl/flash_cmd_out.sv
module flash_cmd_out
  import flash_cmd_pkg::*;
#(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  cmd_op_e           ev_op,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic              cmd_valid,
  output logic [3:0]        cmd_op,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [DATA_W-1:0] cmd_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_valid <= 1'b0;
      cmd_op    <= OP_NONE;
      cmd_addr  <= '0;
      cmd_data  <= '0;
    end else begin
      cmd_valid <= (ev_op != OP_NONE);
      cmd_op    <= ev_op;
      if (ev_op != OP_NONE) begin
        cmd_addr <= addr;
        cmd_data <= data;
      end
    end
  end

  // R2: a pulse always names a real operation
  p_pulse_named_r2: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> (cmd_op != OP_NONE && cmd_op <= OP_ID_EXIT));

endmodule

// File: rtl/flash_id_rom.sv
module flash_id_rom #(
  parameter int unsigned ADDR_W   = 20,
  parameter int unsigned DATA_W   = 16,
  parameter logic [7:0]  MFR_CODE = 8'h1F,
  parameter logic [7:0]  DEV_CODE = 8'hC0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              id_active,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] id_rdata
);
  localparam logic [ADDR_W-1:0] LOC_MFR = '0;
  localparam logic [ADDR_W-1:0] LOC_DEV = ADDR_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      id_rdata <= '0;
    end else if (id_active && rd_addr == LOC_MFR) begin
      id_rdata <= DATA_W'(MFR_CODE);
    end else if (id_active && rd_addr == LOC_DEV) begin
      id_rdata <= DATA_W'(DEV_CODE);
    end else begin
      id_rdata <= '0;
    end
  end

  // R9: codes appear only while identification mode was on
  p_id_gated_r9: assert property (@(posedge clk) disable iff (rst)
    (id_rdata != '0) |-> $past(id_active));

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int unsigned ADDR_W   = 20,
  parameter int unsigned DATA_W   = 16,
  parameter logic [7:0]  MFR_CODE = 8'h1F,
  parameter logic [7:0]  DEV_CODE = 8'hC0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              busy,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              cmd_valid,
  output logic [3:0]        cmd_op,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [DATA_W-1:0] cmd_data,
  output logic              bypass_active,
  output logic              id_active,
  output logic [DATA_W-1:0] id_rdata
);
  logic                fire;
  logic                at_hi, at_lo;
  logic [MATCH_DW-1:0] code;
  cmd_op_e             ev_op;

  assign fire = wr_valid && !busy;   // R10

  flash_key_match u_match (
    .addr_lo (wr_addr[MATCH_AW-1:0]),
    .data_lo (wr_data[MATCH_DW-1:0]),
    .at_hi   (at_hi),
    .at_lo   (at_lo),
    .code    (code)
  );

  flash_seq_fsm u_fsm (
    .clk      (clk),
    .rst      (rst),
    .fire     (fire),
    .at_hi    (at_hi),
    .at_lo    (at_lo),
    .code     (code),
    .ev_op    (ev_op),
    .bypass_q (bypass_active),
    .id_q     (id_active)
  );

  flash_cmd_out #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_out (
    .clk       (clk),
    .rst       (rst),
    .ev_op     (ev_op),
    .addr      (wr_addr),
    .data      (wr_data),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_addr  (cmd_addr),
    .cmd_data  (cmd_data)
  );

  flash_id_rom #(.ADDR_W(ADDR_W), .DATA_W(DATA_W),
                 .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)) u_id (
    .clk       (clk),
    .rst       (rst),
    .id_active (id_active),
    .rd_addr   (rd_addr),
    .id_rdata  (id_rdata)
  );

  // R10: writes under busy never produce a pulse
  p_busy_ignored_r10: assert property (@(posedge clk) disable iff (rst)
    busy |=> !cmd_valid);

  // R2: every pulse follows an accepted write one cycle earlier
  p_pulse_from_write_r2: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> $past(wr_valid && !busy));

endmodule

// File: tb/sim_flash_cmd_decoder.sv
module sim_flash_cmd_decoder;
  localparam int AW = 20;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_valid = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic          busy = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic          cmd_valid;
  logic [3:0]    cmd_op;
  logic [AW-1:0] cmd_addr;
  logic [DW-1:0] cmd_data;
  logic          bypass_active, id_active;
  logic [DW-1:0] id_rdata;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // reference model state: 0 idle,1 key1,2 key2,3 arm,4 ext3,5 ext4,6 ext5
  int m_st;
  bit m_byp, m_id;

  always #10 clk = ~clk;   // 50 MHz

  flash_cmd_decoder u0 (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .busy(busy), .rd_addr(rd_addr),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
    .cmd_data(cmd_data), .bypass_active(bypass_active),
    .id_active(id_active), .id_rdata(id_rdata)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int model_step(input logic [AW-1:0] a,
                                    input logic [DW-1:0] d, input bit b);
    bit hi = (a[15:0] == 16'h5555);
    bit lo = (a[15:0] == 16'h2AAA);
    logic [7:0] c = d[7:0];
    int op = 0;
    if (b) return 0;
    if (m_byp) return 1;
    case (m_st)
      0: begin
        if (hi && c == 8'hAA) m_st = 1;
        else if (c == 8'hB0) op = 5;
        else if (c == 8'h30) op = 6;
        else if (c == 8'hF0) begin op = 8; m_id = 0; end
      end
      1: m_st = (lo && c == 8'h55) ? 2 : 0;
      2: begin
        m_st = 0;
        if (hi && c == 8'hA0) m_st = 3;
        else if (hi && c == 8'h80) m_st = 4;
        else if (hi && c == 8'h90) begin op = 7; m_id = 1; end
        else if (hi && c == 8'hF0) begin op = 8; m_id = 0; end
      end
      3: begin op = 1; m_st = 0; end
      4: m_st = (hi && c == 8'hAA) ? 5 : 0;
      5: m_st = (lo && c == 8'h55) ? 6 : 0;
      default: begin
        m_st = 0;
        if (c == 8'h30) op = 3;
        else if (c == 8'h40) op = 4;
        else if (hi && c == 8'h10) op = 2;
        else if (hi && c == 8'hA0) m_byp = 1;
      end
    endcase
    return op;
  endfunction

  // one write, then compare the pulse registered at the next edge
  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d,
                    input bit b, input string req);
    int eop;
    eop = model_step(a, d, b);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d; busy = b;
    @(negedge clk);
    wr_valid = 1'b0; busy = 1'b0;
    chk(cmd_valid == (eop != 0), req, "cmd_valid", int'(cmd_valid), int'(eop != 0));
    if (eop != 0) begin
      chk(cmd_op == 4'(eop), req, "cmd_op", int'(cmd_op), eop);
      chk(cmd_addr == a, req, "cmd_addr", int'(cmd_addr), int'(a));
      chk(cmd_data == d, req, "cmd_data", int'(cmd_data), int'(d));
    end
    chk(bypass_active == m_byp, req, "bypass_active", int'(bypass_active), int'(m_byp));
    chk(id_active == m_id, req, "id_active", int'(id_active), int'(m_id));
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    m_st = 0; m_byp = 0; m_id = 0;
  endtask

  task automatic rd_chk(input logic [AW-1:0] a, input int exp, input string req);
    @(negedge clk); rd_addr = a;
    @(negedge clk);
    chk(id_rdata == DW'(exp), req, "id_rdata", int'(id_rdata), exp);
  endtask

  task automatic prefix(input string req);
    wr(20'h05555, 16'h00AA, 0, req);
    wr(20'h02AAA, 16'h0055, 0, req);
  endtask

  task automatic ext5(input string req);
    prefix(req); wr(20'h05555, 16'h0080, 0, req); prefix(req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    do_reset();
    // R1: reset state
    chk(!cmd_valid, "R1", "cmd_valid", int'(cmd_valid), 0);
    chk(!bypass_active && !id_active, "R1", "modes", int'({bypass_active, id_active}), 0);
    rd_chk(20'h0, 0, "R1");

    // R2: program
    prefix("R2"); wr(20'h05555, 16'h00A0, 0, "R2");
    wr(20'h12345, 16'hBEEF, 0, "R2");
    // R12: upper bits ignored for matching, carried on the outputs
    wr(20'hF5555, 16'h77AA, 0, "R12"); wr(20'h32AAA, 16'h1255, 0, "R12");
    wr(20'hA5555, 16'hFFA0, 0, "R12"); wr(20'hABCDE, 16'h1357, 0, "R12");
    // R3 chip erase, R4 sector erase and lockout
    ext5("R3"); wr(20'h05555, 16'h0010, 0, "R3");
    ext5("R4"); wr(20'h40123, 16'h0030, 0, "R4");
    ext5("R4"); wr(20'hF8001, 16'h0040, 0, "R4");
    // R7 suspend, resume
    wr(20'h7B3C1, 16'h00B0, 0, "R7");
    wr(20'hC0000, 16'h0030, 0, "R7");
    // R8/R9 identification
    prefix("R8"); wr(20'h05555, 16'h0090, 0, "R8");
    rd_chk(20'h0, 8'h1F, "R9"); rd_chk(20'h1, 8'hC0, "R9"); rd_chk(20'h2, 0, "R9");
    wr(20'h00123, 16'h00F0, 0, "R8");
    rd_chk(20'h0, 0, "R9");
    prefix("R8"); wr(20'h05555, 16'h0090, 0, "R8");
    prefix("R8"); wr(20'h05555, 16'h00F0, 0, "R8");
    // R11 broken sequences
    prefix("R11"); wr(20'h05555, 16'h0077, 0, "R11");
    wr(20'h05555, 16'h00A0, 0, "R11"); wr(20'h01000, 16'h0022, 0, "R11");
    ext5("R11"); wr(20'h05554, 16'h0010, 0, "R11");
    // R10 busy writes skipped
    wr(20'h05555, 16'h00AA, 0, "R10"); wr(20'h02AAA, 16'h0055, 1, "R10");
    wr(20'h00000, 16'h00B0, 1, "R10");
    wr(20'h02AAA, 16'h0055, 0, "R10"); wr(20'h05555, 16'h00A0, 0, "R10");
    wr(20'h00444, 16'h4444, 0, "R10");

    // random mix against the model
    do_reset();
    for (int i = 0; i < 3000; i++) begin
      logic [AW-1:0] a; logic [DW-1:0] d; bit b;
      case ($urandom % 4)
        0: a = {4'($urandom), 16'h5555};
        1: a = {4'($urandom), 16'h2AAA};
        2: a = 20'($urandom);
        default: a = 20'h05555;
      endcase
      d[15:8] = 8'($urandom);
      case ($urandom % 12)
        0, 1: d[7:0] = 8'hAA;
        2, 3: d[7:0] = 8'h55;
        4: d[7:0] = 8'hA0;
        5: d[7:0] = 8'h80;
        6: d[7:0] = 8'h10;
        7: d[7:0] = 8'h30;
        8: d[7:0] = 8'h40;
        9: d[7:0] = 8'h90;
        10: d[7:0] = (($urandom % 2) == 0) ? 8'hF0 : 8'hB0;
        default: d[7:0] = 8'($urandom);
      endcase
      b = (($urandom % 10) == 0);
      wr(a, d, b, "R11");
    end

    // R5/R6 bypass
    do_reset();
    ext5("R5"); wr(20'h05555, 16'h00A0, 0, "R5");
    wr(20'h01111, 16'h00B0, 0, "R5"); wr(20'h20002, 16'h0030, 0, "R5");
    wr(20'h05555, 16'h00F0, 0, "R5"); wr(20'h00003, 16'h00AA, 1, "R10");
    prefix("R6"); wr(20'h05555, 16'h00F0, 0, "R6");
    do_reset();
    chk(!bypass_active, "R6", "bypass after reset", int'(bypass_active), 0);
    wr(20'h00000, 16'h00B0, 0, "R6");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule